// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits on the device side of a 16-bit NOR-style flash model and serves a synchronous bus. The bus carries an address, write data and three active-low strobes: chip enable, write enable and output enable. A clock cycle with chip enable and write enable both low counts as one bus write. A clock cycle with chip enable and output enable low while write enable is high counts as one bus read. Writes are not stored directly. The block decodes them as unlock and command sequences that program one word or erase a sector, a block or the whole array.

Once a command is accepted, the block stays busy for a fixed, parameterised number of cycles. During that time it ignores every write. A read during that time returns a status word instead of array data. Bit 7 of the status word gives the polling value and bit 6 toggles on each read. The array is a small register array that takes a few chosen address bits, so erase regions and program targets behave as they would on a full-size part.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset every array word reads as FFFFh, and `rdDrive` is 0 until the first read.
- R2: A read cycle (ceN=0, oeN=0, weN=1) returns its word on `rdData` with `rdDrive`=1 one clock later. After any cycle that is not a read, `rdDrive` is 0.
- R3: Four writes program a word: AAh at 05555h, then 55h at 02AAAh, then A0h at 05555h, then the data at the target address. Only data bits 7:0 are compared against the command bytes. Once the program ends, the target word reads back the fourth write's data.
- R4: A write that does not match the expected step returns the decoder to idle and leaves the array unchanged. That write does not begin a new sequence, even if it is AAh at 05555h.
- R5: Sector erase is AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h, 55h@02AAAh, then 30h at any address. It sets to FFFFh every word whose address bits 18:11 match that address, and changes no other word.
- R6: Block erase uses the same five writes, then 50h at any address. It sets to FFFFh every word whose address bits 18:15 match that address.
- R7: Chip erase uses the same five writes, then 10h at 05555h, and sets every word to FFFFh. If the final 10h goes to any other address, nothing is erased.
- R8: Writes issued while busy have no effect. They change no word and leave no partial sequence behind once the block is idle again.
- R9: While a program is busy, a read returns bit 7 = inverse of bit 7 of the programmed data, bit 6 = toggle bit, and all other bits 0. The toggle bit is 0 on the first read after the command and inverts after every read made while busy.
- R10: While an erase is busy, a read returns bit 7 = 0, bit 6 = toggle bit (as in R9), and all other bits 0.
- R11: Busy lasts exactly PROG_CYC cycles (program) or ERASE_CYC cycles (erase) after the final write cycle. A read in the last of those cycles returns status, and a read in the next cycle returns array data.
- R12: The array keeps address bits 15, 12:11 and 1:0. Addresses that differ only in other bits refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 19 | Word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid when rdDrive is 1 |
| rdDrive | output | 1 | Read bus drive enable; 0 means high impedance |

## Verification
Some behaviours are checked by assertions on every cycle. The decoder stays idle while busy, the busy counter moves by exactly one each cycle, and the toggle bit inverts on each busy read. An erase status never shows bit 7 high, and the low status bits stay zero. A committed program lands in the right word, and a chip erase leaves the array ones. Other behaviours can only be shown by the bench scenarios. These are the exact cycle where status gives way to data, which words an erase region covers and which it spares, address aliasing, and the rule that a broken or busy-time sequence does not restart decoding.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [15:0] UNLOCK_ADR1 = 16'h5555;
  localparam logic [15:0] UNLOCK_ADR2 = 16'h2AAA;
  localparam logic [7:0]  KEY_FIRST   = 8'hAA;
  localparam logic [7:0]  KEY_SECOND  = 8'h55;
  localparam logic [7:0]  CMD_PROGRAM = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_SECTOR  = 8'h30;
  localparam logic [7:0]  CMD_BLOCK   = 8'h50;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_UNL1, SEQ_UNL2, SEQ_PROG, SEQ_ERA1, SEQ_ERA2, SEQ_ERA3
  } seq_e;

  typedef enum logic [1:0] {
    ERASE_SECTOR, ERASE_BLOCK, ERASE_CHIP
  } erase_kind_e;

  typedef struct packed {
    logic        latchProg;
    logic        latchErase;
    erase_kind_e kind;
    logic        commit;
    logic        busy;
    logic        toggleBit;
  } ctrl_strb_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busByte,
  output ctrl_strb_t        strb
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W-1:0] ADR1 = ADDR_W'(UNLOCK_ADR1);
  localparam logic [ADDR_W-1:0] ADR2 = ADDR_W'(UNLOCK_ADR2);

  seq_e             seqQ, seqD;
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             toggleQ;
  logic             startProg, startErase;
  erase_kind_e      kindD;
  logic             isAdr1, isAdr2, commit;

  assign isAdr1 = (busAddr == ADR1);
  assign isAdr2 = (busAddr == ADR2);
  assign commit = busyQ && (cntQ == CNT_W'(1));

  // sequence decoder: only advances while idle
  always_comb begin
    seqD       = seqQ;
    startProg  = 1'b0;
    startErase = 1'b0;
    kindD      = ERASE_SECTOR;
    if (!busyQ && wrStrobe) begin
      seqD = SEQ_IDLE;
      unique case (seqQ)
        SEQ_IDLE: if (isAdr1 && busByte == KEY_FIRST)  seqD = SEQ_UNL1;
        SEQ_UNL1: if (isAdr2 && busByte == KEY_SECOND) seqD = SEQ_UNL2;
        SEQ_UNL2: begin
          if (isAdr1 && busByte == CMD_PROGRAM)    seqD = SEQ_PROG;
          else if (isAdr1 && busByte == CMD_ERASE) seqD = SEQ_ERA1;
        end
        SEQ_PROG: startProg = 1'b1;
        SEQ_ERA1: if (isAdr1 && busByte == KEY_FIRST)  seqD = SEQ_ERA2;
        SEQ_ERA2: if (isAdr2 && busByte == KEY_SECOND) seqD = SEQ_ERA3;
        SEQ_ERA3: begin
          if (busByte == CMD_SECTOR) begin
            startErase = 1'b1;
            kindD      = ERASE_SECTOR;
          end else if (busByte == CMD_BLOCK) begin
            startErase = 1'b1;
            kindD      = ERASE_BLOCK;
          end else if (busByte == CMD_CHIP && isAdr1) begin
            startErase = 1'b1;
            kindD      = ERASE_CHIP;
          end
        end
        default: seqD = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ    <= SEQ_IDLE;
      busyQ   <= 1'b0;
      cntQ    <= '0;
      toggleQ <= 1'b0;
    end else begin
      seqQ <= seqD;
      if (startProg || startErase) begin
        busyQ   <= 1'b1;
        cntQ    <= startProg ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);
        toggleQ <= 1'b0;
      end else if (busyQ) begin
        cntQ <= cntQ - CNT_W'(1);
        if (commit)   busyQ   <= 1'b0;
        if (rdStrobe) toggleQ <= ~toggleQ;
      end
    end
  end

  assign strb.latchProg  = startProg;
  assign strb.latchErase = startErase;
  assign strb.kind       = kindD;
  assign strb.commit     = commit;
  assign strb.busy       = busyQ;
  assign strb.toggleBit  = toggleQ;

  AST_BUSY_DECODER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> seqQ == SEQ_IDLE); // R8
  AST_BUSY_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && !commit |=> busyQ && (cntQ == $past(cntQ) - CNT_W'(1))); // R11
  AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && rdStrobe |=> toggleQ != $past(toggleQ)); // R9

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int SECT_LSB  = 11,
  parameter int BLK_LSB   = 15,
  parameter int WORD_KEEP = 2,
  parameter int SECT_KEEP = 2,
  parameter int BLK_KEEP  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  ctrl_strb_t        strb,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);

  localparam int IDX_W = WORD_KEEP + SECT_KEEP + BLK_KEEP;
  localparam int WORDS = 1 << IDX_W;
  localparam int REG_W = IDX_W - WORD_KEEP;

  function automatic logic [IDX_W-1:0] idxOf(input logic [ADDR_W-1:0] a);
    return {a[BLK_LSB +: BLK_KEEP], a[SECT_LSB +: SECT_KEEP], a[0 +: WORD_KEEP]};
  endfunction

  logic [DATA_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]  tgtIdx;
  logic [DATA_W-1:0] tgtData;
  erase_kind_e       tgtKind;
  logic              tgtIsProg;
  logic [WORDS-1:0]  eraseHit;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] rdDataQ;
  logic              rdDriveQ;
  logic              unusedAddr;

  assign unusedAddr = ^busAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtIdx    <= '0;
      tgtData   <= '0;
      tgtKind   <= ERASE_SECTOR;
      tgtIsProg <= 1'b0;
    end else if (strb.latchProg) begin
      tgtIdx    <= idxOf(busAddr);
      tgtData   <= busData;
      tgtIsProg <= 1'b1;
    end else if (strb.latchErase) begin
      tgtIdx    <= idxOf(busAddr);
      tgtKind   <= strb.kind;
      tgtIsProg <= 1'b0;
    end
  end

  // per-word erase region match
  for (genvar w = 0; w < WORDS; w++) begin : g_hit
    localparam logic [IDX_W-1:0] WI = IDX_W'(w);
    logic sameBlock, sameSector;
    assign sameBlock  = WI[IDX_W-1 -: BLK_KEEP] == tgtIdx[IDX_W-1 -: BLK_KEEP];
    assign sameSector = WI[IDX_W-1 -: REG_W] == tgtIdx[IDX_W-1 -: REG_W];
    assign eraseHit[w] = (tgtKind == ERASE_CHIP)
                      || (tgtKind == ERASE_BLOCK  && sameBlock)
                      || (tgtKind == ERASE_SECTOR && sameSector);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '1;
    end else if (strb.commit) begin
      if (tgtIsProg) mem[tgtIdx] <= tgtData;
      else begin
        for (int w = 0; w < WORDS; w++) if (eraseHit[w]) mem[w] <= '1;
      end
    end
  end

  always_comb begin
    statusWord    = '0;
    statusWord[7] = tgtIsProg ? ~tgtData[7] : 1'b0;
    statusWord[6] = strb.toggleBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDriveQ <= 1'b0;
      rdDataQ  <= '0;
    end else begin
      rdDriveQ <= rdStrobe;
      if (rdStrobe) rdDataQ <= strb.busy ? statusWord : mem[idxOf(busAddr)];
    end
  end

  assign rdData  = rdDataQ;
  assign rdDrive = rdDriveQ;

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    rdDriveQ && $past(strb.busy && !tgtIsProg) |-> rdDataQ[7] == 1'b0); // R10
  AST_STATUS_QUIET_BITS: assert property (@(posedge clk) disable iff (!rstN)
    rdDriveQ && $past(strb.busy) |-> rdDataQ[5:0] == '0 && rdDataQ[DATA_W-1:8] == '0); // R9
  AST_PROGRAM_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && tgtIsProg |=> mem[$past(tgtIdx)] == $past(tgtData)); // R3
  AST_CHIP_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && !tgtIsProg && tgtKind == ERASE_CHIP |=> mem[0] == '1 && mem[WORDS-1] == '1); // R7

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);

  logic       wrStrobe, rdStrobe;
  ctrl_strb_t strb;

  assign wrStrobe = !ceN && !weN;
  assign rdStrobe = !ceN && !oeN && weN;

  flash_cmd_ctrl #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .busAddr(addr), .busByte(wrData[7:0]), .strb(strb)
  );

  flash_cmd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .busAddr(addr),
    .busData(wrData), .strb(strb), .rdData(rdData), .rdDrive(rdDrive)
  );

endmodule

// File: tb/flash_cmd_top_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_top_tb_top;

  localparam int TB_PROG  = 8;
  localparam int TB_ERASE = 12;

  logic        clk = 1'b0;
  logic        rstN, ceN, weN, oeN;
  logic [18:0] addr;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        rdDrive;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_top #(
    .ADDR_W(19), .DATA_W(16), .PROG_CYC(TB_PROG), .ERASE_CYC(TB_ERASE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive)
  );

  // entry: {kind[1:0] (0 idle,1 write,2 read), req[3:0], addr[18:0], data[15:0]}
  localparam int NV = 24;
  localparam logic [40:0] VEC [NV] = '{
    {2'd2, 4'd1,  19'h00000, 16'hFFFF}, // R1 erased after reset
    {2'd1, 4'd3,  19'h05555, 16'h00AA},
    {2'd1, 4'd3,  19'h02AAA, 16'h0055},
    {2'd1, 4'd3,  19'h05555, 16'h00A0},
    {2'd1, 4'd3,  19'h00001, 16'h1234},
    {2'd2, 4'd9,  19'h00001, 16'h0080}, // R9 inverted bit 7, toggle 0
    {2'd2, 4'd9,  19'h00001, 16'h00C0}, // R9 toggle 1
    {2'd0, 4'd0,  19'h00000, 16'h0000},
    {2'd0, 4'd0,  19'h00000, 16'h0000},
    {2'd0, 4'd0,  19'h00000, 16'h0000},
    {2'd0, 4'd0,  19'h00000, 16'h0000},
    {2'd0, 4'd0,  19'h00000, 16'h0000},
    {2'd2, 4'd11, 19'h00001, 16'h0080}, // R11 last busy cycle
    {2'd2, 4'd3,  19'h00001, 16'h1234}, // R3 true data
    {2'd1, 4'd3,  19'h05555, 16'hFFAA}, // upper byte ignored
    {2'd1, 4'd3,  19'h02AAA, 16'h1255},
    {2'd1, 4'd3,  19'h05555, 16'h77A0},
    {2'd1, 4'd3,  19'h00803, 16'hA5A5},
    {2'd2, 4'd9,  19'h00803, 16'h0000}, // R9 bit7 of A5 set -> 0
    {2'd0, 4'd0,  19'h00000, 16'h0000},
    {2'd0, 4'd0,  19'h00000, 16'h0000},
    {2'd0, 4'd0,  19'h00000, 16'h0000},
    {2'd0, 4'd0,  19'h00000, 16'h0000},
    {2'd0, 4'd0,  19'h00000, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic opIdle(input int n);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic opWrite(input logic [18:0] a, input logic [15:0] d);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; addr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic opRead(input logic [18:0] a, input logic [15:0] exp, input string req);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    check({req, " drive"}, {15'd0, rdDrive}, 16'd1);
    check(req, rdData, exp);
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic progWord(input logic [18:0] a, input logic [15:0] d);
    opWrite(19'h05555, 16'h00AA);
    opWrite(19'h02AAA, 16'h0055);
    opWrite(19'h05555, 16'h00A0);
    opWrite(a, d);
  endtask

  task automatic eraseSeq(input logic [18:0] a, input logic [15:0] cmd);
    opWrite(19'h05555, 16'h00AA);
    opWrite(19'h02AAA, 16'h0055);
    opWrite(19'h05555, 16'h0080);
    opWrite(19'h05555, 16'h00AA);
    opWrite(19'h02AAA, 16'h0055);
    opWrite(a, cmd);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle drive", {15'd0, rdDrive}, 16'd0);

    // table walk: program flows and status reads
    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      kind = VEC[i][40:39];
      if (kind == 2'd1)      opWrite(VEC[i][34:16], VEC[i][15:0]);
      else if (kind == 2'd2) opRead(VEC[i][34:16], VEC[i][15:0], $sformatf("R%0d", VEC[i][38:35]));
      else                   opIdle(1);
    end
    opIdle(TB_PROG);
    opRead(19'h00803, 16'hA5A5, "R3 second word");

    // R2: no drive after a write or with output enable high
    opWrite(19'h00010, 16'h0000);
    check("R2 after write", {15'd0, rdDrive}, 16'd0);
    ceN = 1'b0; oeN = 1'b1; weN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 oe high", {15'd0, rdDrive}, 16'd0);
    ceN = 1'b1;

    // R12: aliasing of unkept bits
    opRead(19'h40803, 16'hA5A5, "R12 bit18 alias");
    opRead(19'h00807, 16'hA5A5, "R12 bit2 alias");

    progWord(19'h08000, 16'h5A5A);
    opIdle(TB_PROG);

    // R4: broken sequences, breaking write does not restart
    opWrite(19'h05555, 16'h00AA);
    opWrite(19'h02AAA, 16'h0056);
    opWrite(19'h05555, 16'h00A0);
    opWrite(19'h00001, 16'h0000);
    opRead(19'h00001, 16'h1234, "R4 wrong key");
    opWrite(19'h05555, 16'h00AA);
    opWrite(19'h02AAA, 16'h0055);
    opWrite(19'h05555, 16'h00AA);
    opWrite(19'h02AAA, 16'h0055);
    opWrite(19'h05555, 16'h00A0);
    opWrite(19'h00001, 16'h0000);
    opRead(19'h00001, 16'h1234, "R4 no restart");

    // R8: writes during a program are ignored
    progWord(19'h00002, 16'h0F0F);
    eraseSeq(19'h05555, 16'h0010);
    opWrite(19'h05555, 16'h00AA);
    opIdle(TB_PROG);
    opRead(19'h00002, 16'h0F0F, "R8 program intact");
    opRead(19'h00001, 16'h1234, "R8 no chip erase");
    opWrite(19'h02AAA, 16'h0055);
    opWrite(19'h05555, 16'h00A0);
    opWrite(19'h00003, 16'h0000);
    opRead(19'h00003, 16'hFFFF, "R8 no leftover sequence");

    // R5 and R10: sector erase of sector 1
    eraseSeq(19'h00800, 16'h0030);
    opRead(19'h00803, 16'h0000, "R10 erase status t0");
    opRead(19'h00803, 16'h0040, "R10 erase status t1");
    opIdle(TB_ERASE - 3);
    opRead(19'h00803, 16'h0000, "R11 erase last busy");
    opRead(19'h00803, 16'hFFFF, "R5 sector erased");
    opRead(19'h00001, 16'h1234, "R5 other sector kept");
    opRead(19'h08000, 16'h5A5A, "R5 other block kept");

    // R6: block erase of block 1
    eraseSeq(19'h08123, 16'h0050);
    opIdle(TB_ERASE);
    opRead(19'h08000, 16'hFFFF, "R6 block erased");
    opRead(19'h00001, 16'h1234, "R6 block 0 kept");

    // R7: chip erase wrong address, then correct
    eraseSeq(19'h00001, 16'h0010);
    opRead(19'h00001, 16'h1234, "R7 wrong address");
    eraseSeq(19'h05555, 16'h0010);
    opIdle(TB_ERASE);
    opRead(19'h00001, 16'hFFFF, "R7 chip erased");
    opRead(19'h00002, 16'hFFFF, "R7 chip erased other");

    opIdle(2);
    finish();
  end

endmodule